// File: doc/BRIEF.md
# Paged Frame Buffer Allocator

This block keeps track of which pages of a shared frame memory are free. The memory is divided into fixed 512-byte pages (1024 of them by default, 4 Mbit in total; with a 64-bit data path one page is 64 words). When a frame arrives, the requester gives its byte length, its destination port, the flow-control setting and the congestion flags of all ports. The block answers with a status and a page count. When the frame is accepted, it then streams out the page indices that will hold the frame, one per cycle. Every frame uses between one and three pages.

Admission is decided in a single cycle:
- A length of zero, or a length larger than three pages, is refused as malformed.
- With flow control off, a frame whose destination port is flagged as congested is dropped before any page is spent. This keeps the shared memory available for traffic to uncongested ports.
- With flow control on, the congestion flags are not consulted.
- A frame that needs more pages than are free is refused as a whole. No page is taken.

Freed pages come back one per cycle through a release input once their frame has left. The free pool behaves as a first-in first-out list. After reset it holds every index in ascending order. Released pages queue behind the ones that have never been used.

Top module: `frame_page_pool`

## Requirements
- R1: After reset `free_count` equals the number of pages, `req_ready` is 1 and `resp_valid` and `grant_valid` are 0.
- R2: An accepted frame of length L reports status code 0 (OK) and `resp_pages` = ceil(L/512), which lies between 1 and 3.
- R3: A length of 0 or above 1536 reports status code 2 (bad length), with `resp_pages` 0 and no grants.
- R4: With `fc_enable` 0 and `port_congested[req_dst]` 1, a valid-length frame reports status code 3 (dropped), and no pages are granted or removed from the pool.
- R5: With `fc_enable` 1, the congestion flags have no effect on the outcome; only page availability decides.
- R6: A frame needing more pages than `free_count` reports status code 1 (no space), and `free_count` is left unchanged (all or nothing).
- R7: After an OK response, the pages appear on `grant_page` with `grant_valid` on consecutive cycles, the first one cycle after the response. `grant_last` marks the final page. `req_ready` stays 0 until the last grant is presented.
- R8: Pages are handed out in first-in first-out order. After reset this is 0, 1, 2 and so on ascending. Released indices are reissued after all never-used ones, in the order they were released.
- R9: Each `rel_valid` adds one page to `free_count` and each grant removes one. A release in the same cycle as a grant leaves the count consistent, and the count never exceeds the number of pages.
- R10: `resp_valid` pulses for exactly one cycle, one cycle after a request is taken (`req_valid` and `req_ready` high at a clock edge).
- R11: Outcomes are checked in this priority: bad length first, then congestion drop, then no space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Block can take a request (no grant burst in progress) |
| req_len | input | LEN_W (12) | Frame length in bytes |
| req_dst | input | PORT_W (4) | Destination port of the frame |
| fc_enable | input | 1 | Flow control enabled; when 1 congestion is ignored |
| port_congested | input | NUM_PORTS (16) | Congestion flag per port |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 2 | 0 OK, 1 no space, 2 bad length, 3 dropped |
| resp_pages | output | PCNT_W (2) | Pages granted (0 when refused) |
| grant_valid | output | 1 | A granted page index is on `grant_page` |
| grant_page | output | IDX_W (10) | Granted page index |
| grant_last | output | 1 | Final page of the current frame |
| rel_valid | input | 1 | Return a page to the pool |
| rel_page | input | IDX_W (10) | Index of the page being returned |
| free_count | output | CNT_W (11) | Pages currently in the free pool |

## Verification
The response is due one cycle after the accepting edge. The n grants of an accepted frame follow on the next n edges. A release updates `free_count` one edge after it is driven.

The bench drives its inputs on falling edges. It checks the response at the first falling edge after the accepting edge, then each grant at the following falling edges. Just after the final grant it checks `req_ready` and `free_count`.

Expected statuses, page counts and page indices come from a queue model of the pool kept in the bench. A sweep covers every length boundary (0, 1, 511, 512, 513, 1024, 1025, 1536, 1537, 4095) under each flow-control and congestion combination. An exhaustion sequence then checks exact-fit, priority and simultaneous release.

// File: rtl/fpa_pkg.sv
// Package: shared types for the paged frame buffer allocator.
// Assumes nothing beyond being compiled before the modules that import it.
package fpa_pkg;

    // Response codes; the values are part of the external contract.
    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_NO_SPACE = 2'd1,
        ST_BAD_LEN  = 2'd2,
        ST_DROPPED  = 2'd3
    } alloc_status_e;

endpackage

// File: rtl/fpa_len_classify.sv
// Length classifier: turns a frame byte length into a page count and
// flags lengths that are zero or larger than MAX_PAGES pages.
// Assumes PAGE_BYTES is a power of two; purely combinational.
module fpa_len_classify #(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 512,
    parameter int MAX_PAGES  = 3,
    parameter int PCNT_W     = 2
) (
    input  logic [LEN_W-1:0]  len,
    output logic              len_ok,
    output logic [PCNT_W-1:0] pages
);
    localparam int MAX_LEN = PAGE_BYTES * MAX_PAGES;
    localparam int PB_SH   = $clog2(PAGE_BYTES);

    logic [LEN_W:0] rounded;

    // Validity: non-zero and within the per-frame page limit.
    always_comb begin
        len_ok = (len != '0) && (32'(len) <= 32'(MAX_LEN));
    end

    // Ceiling division by the page size.
    always_comb begin
        rounded = {1'b0, len} + (LEN_W+1)'(PAGE_BYTES - 1);
        pages   = PCNT_W'(rounded >> PB_SH);
    end

endmodule

// File: rtl/fpa_admit.sv
// Admission decision: picks the response code for one request from the
// length check, the congestion state of the destination port, the flow
// control setting and the pages currently free.
// Priority: bad length, then congestion drop, then lack of space.
module fpa_admit
    import fpa_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = 4,
    parameter int PCNT_W    = 2,
    parameter int CNT_W     = 11
) (
    input  logic                 len_ok,
    input  logic [PCNT_W-1:0]    pages,
    input  logic [PORT_W-1:0]    dst,
    input  logic                 fc_enable,
    input  logic [NUM_PORTS-1:0] congested,
    input  logic [CNT_W-1:0]     free_count,
    output alloc_status_e        status
);
    logic dst_busy;
    logic short_of_pages;

    // Congestion of the destination only matters with flow control off.
    always_comb begin
        dst_busy       = !fc_enable && congested[dst];
        short_of_pages = CNT_W'(pages) > free_count;
    end

    // Prioritised outcome.
    always_comb begin
        if (!len_ok)             status = ST_BAD_LEN;
        else if (dst_busy)       status = ST_DROPPED;
        else if (short_of_pages) status = ST_NO_SPACE;
        else                     status = ST_OK;
    end

endmodule

// File: rtl/fpa_free_list.sv
// Free page list with first-in first-out order.
// Pages never yet issued come from a counter, so no memory has to be
// written at reset. Released pages go into a ring buffer that is read once
// the counter is exhausted. Together these give the same order as a FIFO
// preloaded with 0..NUM_PAGES-1.
// Assumes NUM_PAGES is a power of two, no pop while empty and no push
// while full (the caller guarantees both).
module fpa_free_list #(
    parameter int NUM_PAGES = 1024,
    parameter int IDX_W     = 10,
    parameter int CNT_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] count
);
    logic [IDX_W:0]   fresh_next;
    logic [IDX_W-1:0] ring [NUM_PAGES];
    logic [IDX_W-1:0] rd_ptr;
    logic [IDX_W-1:0] wr_ptr;
    logic [CNT_W-1:0] ring_cnt;
    logic             fresh_avail;
    logic             pop_ring;

    // Head selection: unused pages first, then recycled ones.
    always_comb begin
        fresh_avail = 32'(fresh_next) < NUM_PAGES;
        pop_ring    = pop && !fresh_avail;
        head_idx    = fresh_avail ? fresh_next[IDX_W-1:0] : ring[rd_ptr];
        count       = CNT_W'(NUM_PAGES) - CNT_W'(fresh_next) + ring_cnt;
    end

    // Fresh counter and ring pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_next <= '0;
            rd_ptr     <= '0;
            wr_ptr     <= '0;
            ring_cnt   <= '0;
        end else begin
            if (pop && fresh_avail) fresh_next <= fresh_next + 1'b1;
            if (pop_ring)           rd_ptr     <= rd_ptr + 1'b1;
            if (push)               wr_ptr     <= wr_ptr + 1'b1;
            ring_cnt <= ring_cnt + CNT_W'(push) - CNT_W'(pop_ring);
        end
    end

    // Ring storage for released pages (no reset needed).
    always_ff @(posedge clk) begin
        if (push) ring[wr_ptr] <= push_idx;
    end

endmodule

// File: rtl/frame_page_pool.sv
// Paged frame buffer allocator top.
// Takes one request at a time. Decides admission in the accepting cycle,
// answers with a one-cycle response, then streams the granted page
// indices one per cycle. Releases are accepted every cycle.
// Assumes a release never names a page that is already free.
module frame_page_pool
    import fpa_pkg::*;
#(
    parameter int NUM_PAGES  = 1024,
    parameter int PAGE_BYTES = 512,
    parameter int MAX_PAGES  = 3,
    parameter int LEN_W      = 12,
    parameter int NUM_PORTS  = 16,
    localparam int IDX_W     = $clog2(NUM_PAGES),
    localparam int CNT_W     = $clog2(NUM_PAGES + 1),
    localparam int PCNT_W    = $clog2(MAX_PAGES + 1),
    localparam int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [PORT_W-1:0]    req_dst,
    input  logic                 fc_enable,
    input  logic [NUM_PORTS-1:0] port_congested,
    output logic                 resp_valid,
    output logic [1:0]           resp_status,
    output logic [PCNT_W-1:0]    resp_pages,
    output logic                 grant_valid,
    output logic [IDX_W-1:0]     grant_page,
    output logic                 grant_last,
    input  logic                 rel_valid,
    input  logic [IDX_W-1:0]     rel_page,
    output logic [CNT_W-1:0]     free_count
);
    logic              len_ok;
    logic [PCNT_W-1:0] need_pages;
    alloc_status_e     verdict;
    logic              accept;
    logic              busy;
    logic [PCNT_W-1:0] remain;
    logic [IDX_W-1:0]  head_idx;

    fpa_len_classify #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
        .MAX_PAGES(MAX_PAGES), .PCNT_W(PCNT_W)
    ) i_len (
        .len(req_len), .len_ok(len_ok), .pages(need_pages)
    );

    fpa_admit #(
        .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
        .PCNT_W(PCNT_W), .CNT_W(CNT_W)
    ) i_admit (
        .len_ok(len_ok), .pages(need_pages), .dst(req_dst),
        .fc_enable(fc_enable), .congested(port_congested),
        .free_count(free_count), .status(verdict)
    );

    fpa_free_list #(
        .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) i_list (
        .clk(clk), .rst_n(rst_n), .pop(busy), .push(rel_valid),
        .push_idx(rel_page), .head_idx(head_idx), .count(free_count)
    );

    // Handshake: one request at a time, none during a grant burst.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
    end

    // Response register: one strobe per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= 2'd0;
            resp_pages  <= '0;
        end else begin
            resp_valid <= accept;
            if (accept) begin
                resp_status <= verdict;
                resp_pages  <= (verdict == ST_OK) ? need_pages : '0;
            end
        end
    end

    // Burst sequencer: pops one page per cycle while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (accept && verdict == ST_OK) begin
            busy   <= 1'b1;
            remain <= need_pages;
        end else if (busy) begin
            remain <= remain - 1'b1;
            if (remain == PCNT_W'(1)) busy <= 1'b0;
        end
    end

    // Grant output register: presents each popped index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_page  <= '0;
            grant_last  <= 1'b0;
        end else begin
            grant_valid <= busy;
            grant_last  <= busy && (remain == PCNT_W'(1));
            if (busy) grant_page <= head_idx;
        end
    end

endmodule

// File: rtl/fpa_checker.sv
// Checker for frame_page_pool: protocol and accounting properties.
// Observes ports only; bound to every instance of the top.
module fpa_checker #(
    parameter int NUM_PAGES = 1024,
    parameter int MAX_PAGES = 3,
    parameter int CNT_W     = 11,
    parameter int PCNT_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             fc_enable,
    input logic             resp_valid,
    input logic [1:0]       resp_status,
    input logic [PCNT_W-1:0] resp_pages,
    input logic             grant_valid,
    input logic             grant_last,
    input logic             rel_valid,
    input logic [CNT_W-1:0] free_count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(free_count) <= NUM_PAGES); // R9
    AST_COUNT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_count) == int'($past(free_count)) + int'($past(rel_valid)) - int'(grant_valid)); // R9
    AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready)); // R10
    AST_REFUSED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status != 2'd0) |=> !grant_valid); // R3
    AST_DROP_NEEDS_FC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == 2'd3) |-> $past(!fc_enable)); // R5
    AST_OK_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == 2'd0) |-> (resp_pages != '0 && 32'(resp_pages) <= MAX_PAGES)); // R2
    AST_READY_HELD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_last) |-> !req_ready); // R7
endmodule

bind frame_page_pool fpa_checker #(
    .NUM_PAGES(NUM_PAGES), .MAX_PAGES(MAX_PAGES),
    .CNT_W(CNT_W), .PCNT_W(PCNT_W)
) i_fpa_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .fc_enable(fc_enable), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_pages(resp_pages), .grant_valid(grant_valid), .grant_last(grant_last),
    .rel_valid(rel_valid), .free_count(free_count)
);

// File: tb/test_frame_page_pool.sv
// Bench: sweeps length boundaries over flow-control and congestion
// combinations on a 16-page, 4-port configuration, then exhausts the pool.
module test_frame_page_pool;
    localparam int NP = 16;
    localparam int NPORT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_len = '0;
    logic [1:0]  req_dst = '0;
    logic        fc_enable = 1'b0;
    logic [3:0]  port_congested = '0;
    logic        resp_valid;
    logic [1:0]  resp_status;
    logic [1:0]  resp_pages;
    logic        grant_valid;
    logic [3:0]  grant_page;
    logic        grant_last;
    logic        rel_valid = 1'b0;
    logic [3:0]  rel_page = '0;
    logic [4:0]  free_count;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int freeq[$];
    int held[$];

    frame_page_pool #(.NUM_PAGES(NP), .NUM_PORTS(NPORT)) i_frame_page_pool (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_len(req_len), .req_dst(req_dst), .fc_enable(fc_enable),
        .port_congested(port_congested), .resp_valid(resp_valid),
        .resp_status(resp_status), .resp_pages(resp_pages),
        .grant_valid(grant_valid), .grant_page(grant_page), .grant_last(grant_last),
        .rel_valid(rel_valid), .rel_page(rel_page), .free_count(free_count)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Returns one page; the count is checked one edge later (R9).
    task automatic release_page(input int pg);
        rel_valid = 1'b1;
        rel_page  = 4'(pg);
        @(negedge clk);
        rel_valid = 1'b0;
        freeq.push_back(pg);
        check(free_count == 5'(freeq.size()), "R9 count after release", free_count, freeq.size());
    endtask

    // One request with expected outcome from the queue model.
    task automatic do_req(input int len, input bit fc, input bit cong, input bit keep,
                          input bit rel_en, input int rel_pg);
        int exp_st, need;
        int exp_pg[$];
        need = (len + 511) / 512;
        if (len == 0 || len > 1536)  exp_st = 2;
        else if (!fc && cong)        exp_st = 3;
        else if (need > freeq.size()) exp_st = 1;
        else                         exp_st = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_len   = 12'(len);
        req_dst   = 2'd2;
        fc_enable = fc;
        port_congested = cong ? 4'b0100 : 4'b1011;
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid == 1'b1, "R10 response strobe", resp_valid, 1);
        check(resp_status == 2'(exp_st), "R2/R3/R4/R5/R6/R11 status", resp_status, exp_st);
        check(grant_valid == 1'b0, "R7 no grant with response", grant_valid, 0);
        if (exp_st == 0) begin
            check(resp_pages == 2'(need), "R2 page count", resp_pages, need);
            for (int k = 0; k < need; k++) exp_pg.push_back(freeq.pop_front());
            for (int k = 0; k < need; k++) begin
                if (k == 0 && rel_en) begin
                    rel_valid = 1'b1;
                    rel_page  = 4'(rel_pg);
                end
                @(negedge clk);
                if (k == 0 && rel_en) begin
                    rel_valid = 1'b0;
                    freeq.push_back(rel_pg);
                end
                check(resp_valid == 1'b0, "R10 single strobe", resp_valid, 0);
                check(grant_valid == 1'b1, "R7 grant valid", grant_valid, 1);
                check(grant_page == 4'(exp_pg[k]), "R8 grant order", grant_page, exp_pg[k]);
                check(grant_last == (k == need - 1), "R7 last marker", grant_last, k == need - 1);
                check(req_ready == (k == need - 1), "R7 ready during burst", req_ready, k == need - 1);
            end
            check(free_count == 5'(freeq.size()), "R9 count after grants", free_count, freeq.size());
            foreach (exp_pg[i]) begin
                if (keep) held.push_back(exp_pg[i]);
                else      release_page(exp_pg[i]);
            end
        end else begin
            check(resp_pages == 2'd0, "R3 no pages on refusal", resp_pages, 0);
            check(free_count == 5'(freeq.size()), "R4/R6 count unchanged", free_count, freeq.size());
            @(negedge clk);
            check(grant_valid == 1'b0, "R3/R4 no grant", grant_valid, 0);
            check(resp_valid == 1'b0, "R10 single strobe", resp_valid, 0);
        end
    endtask

    initial begin
        int lens[10] = '{0, 1, 511, 512, 513, 1024, 1025, 1536, 1537, 4095};
        for (int i = 0; i < NP; i++) freeq.push_back(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(free_count == 5'(NP), "R1 free count", free_count, NP);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(resp_valid == 1'b0 && grant_valid == 1'b0, "R1 outputs idle", resp_valid, 0);

        // Sweep: every length boundary under each fc/congestion pairing (R2..R5, R8).
        for (int f = 0; f < 2; f++)
            for (int c = 0; c < 2; c++)
                foreach (lens[i]) do_req(lens[i], f[0], c[0], 1'b0, 1'b0, 0);

        // Exhaust: five 3-page frames leave one page (R6).
        for (int i = 0; i < 5; i++) do_req(1536, 1'b1, 1'b0, 1'b1, 1'b0, 0);
        do_req(1024, 1'b1, 1'b0, 1'b1, 1'b0, 0);   // R6 needs 2, has 1
        do_req(512, 1'b0, 1'b0, 1'b1, 1'b0, 0);    // R6 exact fit
        do_req(1, 1'b1, 1'b0, 1'b1, 1'b0, 0);      // R6 empty pool
        do_req(0, 1'b0, 1'b1, 1'b1, 1'b0, 0);      // R11 bad length wins
        do_req(100, 1'b0, 1'b1, 1'b1, 1'b0, 0);    // R11 drop beats no space
        do_req(100, 1'b1, 1'b1, 1'b1, 1'b0, 0);    // R5 congestion ignored

        // Recycle three pages, then allocate them with a release alongside (R8, R9).
        for (int i = 0; i < 3; i++) release_page(held.pop_front());
        begin
            int extra;
            extra = held.pop_front();
            do_req(1536, 1'b1, 1'b1, 1'b0, 1'b1, extra);
        end
        while (held.size() > 0) release_page(held.pop_front());
        check(free_count == 5'(NP), "R9 all pages back", free_count, NP);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule